// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block is an up/down position counter for a two-channel quadrature encoder. The count source is chosen by a 3-bit field. The counter can step on both edges of channel A only, on both edges of channel B only, or on every single-channel change of the pair (x4). It can also ignore the encoder and advance once per clock. A small register port sets up the block and reads it back. Through that port software can turn counting on, pick the source, load the count and set a wrap ceiling. The count always moves between 0 and that ceiling, both ends included.

Both encoder inputs pass through a synchronizer before edge detection, so they may be asynchronous to the clock. Each wrap at either end of the range produces a one-cycle update pulse. Software can also force an update. An update event copies a pending ceiling into the active ceiling when the ceiling is double-buffered. When the ceiling is not double-buffered, a write to it takes effect at once.

Top module: `qenc_timer`

## Requirements
- R1: After reset, count_o is 0, dir_o is 0, upd_o is 0, the control register reads 0 and the active ceiling reads all ones.
- R2: With source field (control bits 6:4) equal to 0 and the run bit (control bit 0) set, the count rises by one on every clock and dir_o stays 0.
- R3: While the run bit is clear, the count holds its value whatever the encoder inputs do.
- R4: With source 1, each rising and falling edge of A steps the count: up when A equals B after the edge, down otherwise. Edges of B alone do nothing. A pin change shows on count_o after the third rising clock edge.
- R5: With source 2, each edge of B steps the count: up when B differs from A after the edge, down otherwise. Edges of A alone do nothing.
- R6: With source 3, every single change of {A,B} steps the count. Following 00, 01, 11, 10, 00 counts up, and the reverse order counts down.
- R7: A change of A and B in the same synchronized cycle is treated as invalid and leaves the count unchanged.
- R8: Source values 4 to 7 never change the count.
- R9: Counting up from a value at or above the active ceiling gives 0. Counting down from 0 gives the ceiling. upd_o is high for exactly the one cycle in which the wrapped value first appears.
- R10: With the buffer bit (control bit 1) clear, a ceiling write (address 2) changes the active ceiling at once. Address 2 reads the active ceiling.
- R11: With the buffer bit set, a ceiling write is held back, and the active ceiling keeps its old value until the next update event (a wrap or a forced update).
- R12: Writing control with bit 2 set forces an update event. upd_o is high in the next cycle and the held ceiling becomes active. Bit 2 always reads back as 0.
- R13: A count write (address 1) sets the count in the next cycle and overrides any encoder or clock step in the same cycle.
- R14: dir_o, also readable at address 3 bit 0, gives the direction of the last step (1 = down) and holds between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 count, 2 ceiling, 3 status |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data for bus_addr, combinational |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Last step direction, 1 = down |
| upd_o | output | 1 | One-cycle update event pulse |

## Verification
The bench drives Gray-code walks in both directions, steps of a single channel in each two-edge mode, and simultaneous changes of both channels. A decoder with the wrong direction sense, or one that let the inactive channel through, would drift away from the reference count. Wraps are driven at both ends. An off-by-one compare would show either the ceiling value being skipped or an extra count past it. The bench writes a buffered ceiling, then reads it back both before and after the update event, and it also forces an update. A design that loaded the buffered ceiling early, or never loaded it, would return the wrong value at address 2. Count writes collide with clock-driven counting, which exposes a design that lets the step win over the write.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CNT  = 2'd1;
    localparam logic [1:0] ADR_CEIL = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    localparam int CTL_RUN   = 0;
    localparam int CTL_BUF   = 1;
    localparam int CTL_FORCE = 2;
    localparam int CTL_SRC   = 4;
    localparam int SRC_W     = 3;

    localparam logic [SRC_W-1:0] SRC_CLOCK = 3'd0;
    localparam logic [SRC_W-1:0] SRC_A_X2  = 3'd1;
    localparam logic [SRC_W-1:0] SRC_B_X2  = 3'd2;
    localparam logic [SRC_W-1:0] SRC_X4    = 3'd3;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    typedef struct packed {
        logic             run;
        logic             buffered;
        logic [SRC_W-1:0] src;
    } ctrl_t;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int STAGES = 2,
    parameter int CH     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] raw_i,
    output logic [CH-1:0] cur_o,
    output logic [CH-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [DEPTH-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[DEPTH-2:0], raw_i[c]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end

        assign cur_o[c]  = pipe_q[STAGES-1];
        assign prev_o[c] = pipe_q[STAGES];
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic [SRC_W-1:0] src_i,
    input  logic [1:0]       cur_i,
    input  logic [1:0]       prev_i,
    output step_e            step_o
);
    logic a_now, b_now, a_chg, b_chg;
    step_e a_step, b_step;

    always_comb begin
        a_now  = cur_i[0];
        b_now  = cur_i[1];
        a_chg  = cur_i[0] ^ prev_i[0];
        b_chg  = cur_i[1] ^ prev_i[1];
        a_step = (a_now == b_now) ? STEP_UP : STEP_DN;
        b_step = (b_now != a_now) ? STEP_UP : STEP_DN;
        step_o = STEP_NONE;
        unique case (src_i)
            SRC_CLOCK: step_o = STEP_UP;
            SRC_A_X2:  if (a_chg && !b_chg) step_o = a_step;
            SRC_B_X2:  if (b_chg && !a_chg) step_o = b_step;
            SRC_X4: begin
                if (a_chg && !b_chg)      step_o = a_step;
                else if (b_chg && !a_chg) step_o = b_step;
            end
            default:   step_o = STEP_NONE;
        endcase
    end
endmodule

// File: rtl/qenc_wrap.sv
module qenc_wrap
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] ceil_i,
    input  step_e        step_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    always_comb begin
        cnt_o  = cnt_i;
        wrap_o = 1'b0;
        unique case (step_i)
            STEP_UP: begin
                if (cnt_i >= ceil_i) begin
                    cnt_o  = '0;
                    wrap_o = 1'b1;
                end else begin
                    cnt_o = cnt_i + 1'b1;
                end
            end
            STEP_DN: begin
                if (cnt_i == '0) begin
                    cnt_o  = ceil_i;
                    wrap_o = 1'b1;
                end else begin
                    cnt_o = cnt_i - 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             upd_o
);
    localparam logic [CNT_W-1:0] CEIL_RST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ceil_act;
        logic [CNT_W-1:0] ceil_pend;
        ctrl_t            ctrl;
        logic             dir;
        logic             upd;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]       ch_cur, ch_prev;
    step_e            raw_step, eff_step;
    logic [CNT_W-1:0] stepped_cnt;
    logic             stepped_wrap;

    logic             ctrl_run, ctrl_buf;
    logic [SRC_W-1:0] ctrl_src;
    logic [CNT_W-1:0] ceil_act;

    qenc_sync #(.STAGES(SYNC_STAGES), .CH(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({enc_b, enc_a}),
        .cur_o  (ch_cur),
        .prev_o (ch_prev)
    );

    qenc_decode i_decode (
        .src_i  (st_q.ctrl.src),
        .cur_i  (ch_cur),
        .prev_i (ch_prev),
        .step_o (raw_step)
    );

    qenc_wrap #(.W(CNT_W)) i_wrap (
        .cnt_i  (st_q.cnt),
        .ceil_i (st_q.ceil_act),
        .step_i (eff_step),
        .cnt_o  (stepped_cnt),
        .wrap_o (stepped_wrap)
    );

    always_comb begin
        eff_step = STEP_NONE;
        if (st_q.ctrl.run && !(bus_wr && bus_addr == ADR_CNT)) eff_step = raw_step;

        st_d     = st_q;
        st_d.upd = 1'b0;

        if (eff_step != STEP_NONE) begin
            st_d.cnt = stepped_cnt;
            st_d.dir = (eff_step == STEP_DN);
            st_d.upd = stepped_wrap;
        end

        if (bus_wr) begin
            unique case (bus_addr)
                ADR_CTRL: begin
                    st_d.ctrl.run      = bus_wdata[CTL_RUN];
                    st_d.ctrl.buffered = bus_wdata[CTL_BUF];
                    st_d.ctrl.src      = bus_wdata[CTL_SRC +: SRC_W];
                    if (bus_wdata[CTL_FORCE]) st_d.upd = 1'b1;
                end
                ADR_CNT: st_d.cnt = bus_wdata;
                ADR_CEIL: begin
                    st_d.ceil_pend = bus_wdata;
                    if (!st_q.ctrl.buffered) st_d.ceil_act = bus_wdata;
                end
                default: ;
            endcase
        end

        if (st_d.upd) st_d.ceil_act = st_d.ceil_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ceil_act  <= CEIL_RST;
            st_q.ceil_pend <= CEIL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[CTL_RUN]            = st_q.ctrl.run;
                bus_rdata[CTL_BUF]            = st_q.ctrl.buffered;
                bus_rdata[CTL_SRC +: SRC_W]   = st_q.ctrl.src;
            end
            ADR_CNT:  bus_rdata = st_q.cnt;
            ADR_CEIL: bus_rdata = st_q.ceil_act;
            default:  bus_rdata[0] = st_q.dir;
        endcase
    end

    assign count_o  = st_q.cnt;
    assign dir_o    = st_q.dir;
    assign upd_o    = st_q.upd;
    assign ctrl_run = st_q.ctrl.run;
    assign ctrl_buf = st_q.ctrl.buffered;
    assign ctrl_src = st_q.ctrl.src;
    assign ceil_act = st_q.ceil_act;
endmodule

// File: rtl/qenc_timer_chk.sv
module qenc_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] count_o,
    input logic         dir_o,
    input logic         upd_o,
    input logic         run,
    input logic         buffered,
    input logic [2:0]   src,
    input logic [W-1:0] ceil_act
);
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run && !(bus_wr && bus_addr == 2'd1)) |=> $stable(count_o)); // R3
    AST_CLOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && src == 3'd0 && !bus_wr && count_o < ceil_act) |=> (count_o == $past(count_o) + 1'b1 && !dir_o)); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (run && src == 3'd0 && !bus_wr && count_o >= ceil_act) |=> (count_o == '0 && upd_o)); // R9
    AST_CEIL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == 2'd2 && !buffered) |=> (ceil_act == $past(bus_wdata))); // R10
    AST_CEIL_HELD: assert property (@(posedge clk) disable iff (!rst_n) buffered |=> (upd_o || $stable(ceil_act))); // R11
    AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == 2'd0 && bus_wdata[2]) |=> upd_o); // R12
    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == 2'd1) |=> (count_o == $past(bus_wdata))); // R13
    AST_IDLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (src[2] && !(bus_wr && bus_addr == 2'd1)) |=> $stable(count_o)); // R8
endmodule

bind qenc_timer qenc_timer_chk #(.W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_o   (count_o),
    .dir_o     (dir_o),
    .upd_o     (upd_o),
    .run       (ctrl_run),
    .buffered  (ctrl_buf),
    .src       (ctrl_src),
    .ceil_act  (ceil_act)
);

// File: tb/test_qenc_timer.sv
`timescale 1ns/1ps
module test_qenc_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enc_a = 1'b0, enc_b = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata, count_o;
    logic         dir_o, upd_o;

    int n_chk = 0, n_bad = 0;
    bit chk_on = 0;
    bit ended = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    qenc_timer #(.CNT_W(W)) i_qenc_timer (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_o(count_o), .dir_o(dir_o), .upd_o(upd_o)
    );

    // behavioural reference
    int m_cnt, m_ceil, m_pend, m_mode;
    bit m_run, m_pre, m_dir, m_upd;
    bit sa1, sa2, ra, sb1, sb2, rb;

    function automatic int gidx(bit a, bit b);
        if (!a && !b) return 0;
        if (!a && b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ceil = 65535; m_pend = 65535; m_mode = 0;
            m_run = 0; m_pre = 0; m_dir = 0; m_upd = 0;
            sa1 = 0; sa2 = 0; ra = 0; sb1 = 0; sb2 = 0; rb = 0;
        end else begin
            bit ach, bch, up;
            int step, d;
            bit ev;
            ach = (sa2 != ra);
            bch = (sb2 != rb);
            d = (gidx(sa2, sb2) - gidx(ra, rb) + 4) % 4;
            up = (d == 1);
            step = 0;
            if (m_run) begin
                case (m_mode)
                    0: step = 1;
                    1: if (ach && !bch) step = up ? 1 : -1;
                    2: if (bch && !ach) step = up ? 1 : -1;
                    3: if (ach != bch)  step = up ? 1 : -1;
                    default: step = 0;
                endcase
            end
            ev = 0;
            if (bus_wr && bus_addr == 2'd1) m_cnt = int'(bus_wdata);
            else if (step == 1) begin
                m_dir = 0;
                if (m_cnt >= m_ceil) begin m_cnt = 0; ev = 1; end
                else m_cnt = m_cnt + 1;
            end else if (step == -1) begin
                m_dir = 1;
                if (m_cnt == 0) begin m_cnt = m_ceil; ev = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (bus_wr && bus_addr == 2'd2) begin
                m_pend = int'(bus_wdata);
                if (!m_pre) m_ceil = int'(bus_wdata);
            end
            if (bus_wr && bus_addr == 2'd0) begin
                m_run = bus_wdata[0]; m_pre = bus_wdata[1];
                m_mode = int'(bus_wdata[6:4]);
                if (bus_wdata[2]) ev = 1;
            end
            if (ev) m_ceil = m_pend;
            m_upd = ev;
            ra = sa2; sa2 = sa1; sa1 = enc_a;
            rb = sb2; sb2 = sb1; sb1 = enc_b;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !ended) begin
            n_chk++;
            if (int'(count_o) != m_cnt || dir_o != m_dir || upd_o != m_upd) begin
                n_bad++;
                $display("FAIL %s model: cnt=%0d dir=%0d upd=%0d expected cnt=%0d dir=%0d upd=%0d",
                         phase, count_o, dir_o, upd_o, m_cnt, m_dir, m_upd);
            end
        end
    end

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = W'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(int'(bus_rdata), exp, req);
    endtask

    task automatic pins(input bit a, input bit b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        @(negedge clk);
        phase = "R1";
        check(int'(count_o), 0, "R1"); check(int'(dir_o), 0, "R1"); check(int'(upd_o), 0, "R1");
        rd_check(2'd2, 65535, "R1");
        rd_check(2'd0, 0, "R1");

        phase = "R10";
        wr(2'd2, 5);
        rd_check(2'd2, 5, "R10");

        phase = "R13";
        wr(2'd1, 3);
        check(int'(count_o), 3, "R13");

        phase = "R3";
        pins(1, 0); pins(0, 0);
        check(int'(count_o), 3, "R3");

        phase = "R2";
        wr(2'd0, 'h01);
        check(int'(count_o), 3, "R2");
        repeat (3) @(negedge clk);
        check(int'(count_o), 0, "R9"); check(int'(upd_o), 1, "R9");
        repeat (12) @(negedge clk);

        phase = "R6";
        wr(2'd0, 'h00);
        wr(2'd1, 0);
        wr(2'd0, 'h31);
        pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
        check(int'(count_o), 4, "R6"); check(int'(dir_o), 0, "R6");
        pins(1, 0); pins(1, 1);
        check(int'(count_o), 2, "R6"); check(int'(dir_o), 1, "R14");
        rd_check(2'd3, 1, "R14");

        phase = "R7";
        pins(0, 0);
        check(int'(count_o), 2, "R7");

        phase = "R4";
        wr(2'd0, 'h11);
        pins(0, 1);
        check(int'(count_o), 2, "R4");
        pins(1, 1);
        check(int'(count_o), 3, "R4");
        pins(0, 1);
        check(int'(count_o), 2, "R4");

        phase = "R5";
        wr(2'd0, 'h21);
        pins(1, 1);
        check(int'(count_o), 2, "R5");
        pins(1, 0);
        check(int'(count_o), 3, "R5");
        pins(1, 1);
        check(int'(count_o), 2, "R5");

        phase = "R8";
        wr(2'd0, 'h51);
        pins(0, 1); pins(0, 0);
        check(int'(count_o), 2, "R8");

        phase = "R9";
        wr(2'd1, 0);
        wr(2'd0, 'h31);
        pins(1, 0);
        check(int'(count_o), 5, "R9"); check(int'(upd_o), 1, "R9");
        @(negedge clk);
        check(int'(upd_o), 0, "R9");

        phase = "R11";
        wr(2'd0, 'h33);
        wr(2'd2, 9);
        rd_check(2'd2, 5, "R11");
        pins(0, 0);
        check(int'(count_o), 0, "R11");
        rd_check(2'd2, 9, "R11");

        phase = "R12";
        wr(2'd2, 7);
        rd_check(2'd2, 9, "R12");
        wr(2'd0, 'h37);
        check(int'(upd_o), 1, "R12");
        rd_check(2'd2, 7, "R12");
        rd_check(2'd0, 'h33, "R12");

        phase = "R13";
        wr(2'd0, 'h01);
        repeat (10) @(negedge clk);
        wr(2'd1, 2);
        check(int'(count_o), 2, "R13");
        repeat (20) @(negedge clk);

        finish_run();
    end
endmodule